// File: doc/BRIEF.md
# Reduced-Compliance Boundary-Scan Test Port

This block is a serial test port for a chip. A 16-state controller is stepped by the test clock and the mode-select input, and the controller chooses one scan register at a time to sit between the serial data input and the serial data output. Four registers are present: a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification word, and a boundary register whose length is a parameter. The boundary register takes its capture values in parallel from a pin-sample bus.

Some mandatory boundary instructions are deliberately reduced. The boundary cells never drive pins. Their only job is to take a snapshot of the pin ring and shift it out. Update-DR therefore does nothing under any boundary instruction. Two of the instructions also raise a force-high-Z output, which the surrounding chip uses to float its functional outputs. The serial output is shown as a data/enable pair. It is enabled only while a register is shifting, and it changes only on the falling test-clock edge.

Top module: `tap_top`

## Requirements
- R1: From any controller state, five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset. An active-low `rst_n` also places it there.
- R2: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. Both `tdo` and `tdo_oe` update on the falling edge of `tck`, and both are low in reset.
- R3: On entering Test-Logic-Reset, the active instruction becomes 001 (identify). A data scan straight after reset therefore returns the identification word.
- R4: In Capture-IR the instruction shift stage loads 001: its two low bits are 01 and its top bit is 0. The first three bits shifted out of an IR scan are therefore 1, 0, 0.
- R5: The instruction selects the data register as follows. Codes 000, 010 and 100 select the boundary register, which is `BND_LEN` bits long. Code 001 selects the identification register. Code 111 and the reserved codes 011, 101 and 110 select the bypass stage.
- R6: `force_hiz` is high exactly while the active instruction is 000 or 010. It is low under 100 and under every other code.
- R7: In Capture-DR, a boundary instruction copies `pin_ring` into the boundary register. Bit i of `pin_ring` is the i-th bit shifted out.
- R8: Update-DR and Pause-DR leave the active instruction and `force_hiz` unchanged. A shift resumed after Pause-DR continues with the next unshifted bit.
- R9: The bypass stage captures 0 in Capture-DR. During a shift it delays `tdi` by exactly one bit.
- R10: The identification word is laid out as follows: revision in bits 31:28, depth code in 27:23, width code in 22:18, part number in 17:12, manufacturer code in 11:1, and a constant 1 in bit 0. The defaults are 0, 00111, 00100, 0 and 0x2A5. The word is shifted out LSB first.
- R11: Every register shifts only in its own shift state. Data enters at the MSB from `tdi` and leaves at the LSB to `tdo`. A bit shifted in therefore reappears after as many shifts as the register has bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_ring | input | BND_LEN | Parallel sample of the pin ring |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Drive enable for tdo |
| force_hiz | output | 1 | Request to float the functional outputs |

## Verification
The bench aims at chain-length errors first. It checks that the bypass stage gives one bit of delay under every reserved code, because a decoder that sent a reserved code to the boundary register would stretch the chain by 74 bits. Other targets are the capture pattern of the instruction register, the bit order of the identification word, and a shift resumed after Pause-DR: a design that dropped or repeated a bit there would skew every later bit by one. It also tests the five-edge reset from inside a data scan, and `force_hiz` around Update-DR. A design that acted on Update-DR, or that reset the instruction one edge late, would leave the outputs floated after the controller reached reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

   localparam int IR_W = 3;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      SEL_BYP, SEL_ID, SEL_BND
   } chain_sel_e;

   localparam logic [IR_W-1:0] OP_RING_FLOAT  = 3'b000;
   localparam logic [IR_W-1:0] OP_IDENT       = 3'b001;
   localparam logic [IR_W-1:0] OP_SNAP_FLOAT  = 3'b010;
   localparam logic [IR_W-1:0] OP_SNAP        = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS      = 3'b111;

   localparam logic [IR_W-1:0] IR_CAPTURE_VAL = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state,
   output logic       go_reset,
   output logic       cap_ir,
   output logic       shf_ir,
   output logic       upd_ir,
   output logic       cap_dr,
   output logic       shf_dr
);

   tap_state_e nxt;

   always_comb begin
      unique case (state)
         TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
         default:   nxt = TS_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= TS_RESET;
      else        state <= nxt;
   end

   // strobes qualify the coming rising edge
   assign go_reset = (nxt == TS_RESET);
   assign cap_ir   = (state == TS_CAP_IR);
   assign shf_ir   = (state == TS_SHF_IR);
   assign upd_ir   = (state == TS_UPD_IR);
   assign cap_dr   = (state == TS_CAP_DR);
   assign shf_dr   = (state == TS_SHF_DR);

endmodule

// File: rtl/tap_ireg.sv
module tap_ireg
   import tap_pkg::*;
(
   input  logic            tck,
   input  logic            rst_n,
   input  logic            go_reset,
   input  logic            cap,
   input  logic            shf,
   input  logic            upd,
   input  logic            tdi,
   output logic [IR_W-1:0] ir,
   output logic [IR_W-1:0] ir_sh
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= OP_IDENT;
      end else if (cap) begin
         ir_sh <= IR_CAPTURE_VAL;
      end else if (shf) begin
         ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         ir <= OP_IDENT;
      end else if (go_reset) begin
         ir <= OP_IDENT;
      end else if (upd) begin
         ir <= ir_sh;
      end
   end

endmodule

// File: rtl/tap_decode.sv
module tap_decode
   import tap_pkg::*;
(
   input  logic [IR_W-1:0] ir,
   output chain_sel_e      sel,
   output logic            hiz
);

   always_comb begin
      sel = SEL_BYP;
      hiz = 1'b0;
      case (ir)
         OP_RING_FLOAT,
         OP_SNAP_FLOAT: begin
            sel = SEL_BND;
            hiz = 1'b1;
         end
         OP_SNAP:  sel = SEL_BND;
         OP_IDENT: sel = SEL_ID;
         default:  sel = SEL_BYP;
      endcase
   end

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
   import tap_pkg::*;
#(
   parameter int          BND_LEN = 75,
   parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic               cap,
   input  logic               shf,
   input  chain_sel_e         sel,
   input  logic               tdi,
   input  logic [BND_LEN-1:0] pin_ring,
   output logic               byp_q,
   output logic [BND_LEN-1:0] bnd_q,
   output logic               so
);

   localparam int ID_W = 32;

   logic            byp_cap, byp_shf, id_cap, id_shf, bnd_cap, bnd_shf;
   logic [ID_W-1:0] id_q;

   assign byp_cap = cap && (sel == SEL_BYP);
   assign byp_shf = shf && (sel == SEL_BYP);
   assign id_cap  = cap && (sel == SEL_ID);
   assign id_shf  = shf && (sel == SEL_ID);
   assign bnd_cap = cap && (sel == SEL_BND);
   assign bnd_shf = shf && (sel == SEL_BND);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       byp_q <= 1'b0;
      else if (byp_cap) byp_q <= 1'b0;
      else if (byp_shf) byp_q <= tdi;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      id_q <= '0;
      else if (id_cap) id_q <= ID_WORD;
      else if (id_shf) id_q <= {tdi, id_q[ID_W-1:1]};
   end

   for (genvar i = 0; i < BND_LEN; i++) begin : g_cell
      logic cell_q;
      logic cell_in;
      if (i == BND_LEN - 1) begin : g_head
         assign cell_in = tdi;
      end else begin : g_link
         assign cell_in = bnd_q[i+1];
      end
      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n)       cell_q <= 1'b0;
         else if (bnd_cap) cell_q <= pin_ring[i];
         else if (bnd_shf) cell_q <= cell_in;
      end
      assign bnd_q[i] = cell_q;
   end

   always_comb begin
      case (sel)
         SEL_BND: so = bnd_q[0];
         SEL_ID:  so = id_q[0];
         default: so = byp_q;
      endcase
   end

endmodule

// File: rtl/tap_top.sv
module tap_top
   import tap_pkg::*;
#(
   parameter int          BND_LEN  = 75,
   parameter logic [3:0]  ID_REV   = 4'h0,
   parameter logic [4:0]  ID_DEPTH = 5'b00111,
   parameter logic [4:0]  ID_WIDTH = 5'b00100,
   parameter logic [5:0]  ID_PART  = 6'h00,
   parameter logic [10:0] ID_MFR   = 11'h2A5
) (
   input  logic               tck,
   input  logic               rst_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BND_LEN-1:0] pin_ring,
   output logic               tdo,
   output logic               tdo_oe,
   output logic               force_hiz
);

   localparam logic [31:0] ID_WORD = {ID_REV, ID_DEPTH, ID_WIDTH, ID_PART, ID_MFR, 1'b1};

   if (BND_LEN < 2) begin : g_len_chk
      $error("tap_top: BND_LEN must be at least 2");
   end
   if (IR_W < 2) begin : g_ir_chk
      $error("tap_top: instruction register needs two capture bits");
   end

   tap_state_e      state;
   logic            go_reset, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr;
   logic [IR_W-1:0] ir, ir_sh;
   chain_sel_e      sel;
   logic            byp_q, dr_so;
   logic [BND_LEN-1:0] bnd_q;

   tap_fsm u_fsm (
      .tck      (tck),
      .rst_n    (rst_n),
      .tms      (tms),
      .state    (state),
      .go_reset (go_reset),
      .cap_ir   (cap_ir),
      .shf_ir   (shf_ir),
      .upd_ir   (upd_ir),
      .cap_dr   (cap_dr),
      .shf_dr   (shf_dr)
   );

   tap_ireg u_ireg (
      .tck      (tck),
      .rst_n    (rst_n),
      .go_reset (go_reset),
      .cap      (cap_ir),
      .shf      (shf_ir),
      .upd      (upd_ir),
      .tdi      (tdi),
      .ir       (ir),
      .ir_sh    (ir_sh)
   );

   tap_decode u_dec (
      .ir  (ir),
      .sel (sel),
      .hiz (force_hiz)
   );

   tap_dregs #(
      .BND_LEN (BND_LEN),
      .ID_WORD (ID_WORD)
   ) u_dregs (
      .tck      (tck),
      .rst_n    (rst_n),
      .cap      (cap_dr),
      .shf      (shf_dr),
      .sel      (sel),
      .tdi      (tdi),
      .pin_ring (pin_ring),
      .byp_q    (byp_q),
      .bnd_q    (bnd_q),
      .so       (dr_so)
   );

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= shf_ir || shf_dr;
         tdo    <= shf_ir ? ir_sh[0] : dr_so;
      end
   end

endmodule

// File: rtl/tap_chk.sv
module tap_chk
   import tap_pkg::*;
#(
   parameter int BND_LEN = 75
) (
   input logic               tck,
   input logic               rst_n,
   input logic               tms,
   input tap_state_e         state,
   input logic [IR_W-1:0]    ir,
   input logic [IR_W-1:0]    ir_sh,
   input chain_sel_e         sel,
   input logic               byp,
   input logic [BND_LEN-1:0] bnd,
   input logic [BND_LEN-1:0] pin_ring,
   input logic               tdo_oe,
   input logic               force_hiz
);

   logic [2:0] hi_cnt;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= 3'd0;
      else if (!tms)       hi_cnt <= 3'd0;
      else if (hi_cnt < 5) hi_cnt <= hi_cnt + 3'd1;
   end

   // R1
   five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (hi_cnt == 3'd5) |-> (state == TS_RESET));

   // R2
   reset_no_drive_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_RESET) |-> !tdo_oe);

   // R3
   reset_ident_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_RESET) |-> (ir == OP_IDENT));

   // R4
   ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_IR) |=> (ir_sh[1:0] == 2'b01));

   // R6
   reset_outputs_on_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_RESET) |-> !force_hiz);

   // R7
   ring_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_DR && sel == SEL_BND) |=> (bnd == $past(pin_ring)));

   // R8
   update_dr_inert_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_UPD_DR) |=> ($stable(ir) && $stable(force_hiz)));

   // R9
   bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
      (state == TS_CAP_DR && sel == SEL_BYP) |=> !byp);

endmodule

bind tap_top tap_chk #(.BND_LEN(BND_LEN)) u_chk (
   .tck       (tck),
   .rst_n     (rst_n),
   .tms       (tms),
   .state     (state),
   .ir        (ir),
   .ir_sh     (ir_sh),
   .sel       (sel),
   .byp       (byp_q),
   .bnd       (bnd_q),
   .pin_ring  (pin_ring),
   .tdo_oe    (tdo_oe),
   .force_hiz (force_hiz)
);

// File: tb/sim_tap_top.sv
`timescale 1ns/1ps
module sim_tap_top;

   localparam int BL = 75;
   localparam logic [31:0] EXP_ID = {4'h0, 5'b00111, 5'b00100, 6'h00, 11'h2A5, 1'b1};

   // bench-side state numbering
   localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                  S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                  S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

   logic          tck = 1'b0;
   logic          rst_n = 1'b0;
   logic          tms = 1'b1;
   logic          tdi = 1'b0;
   logic [BL-1:0] pins = '0;
   wire           tdo, tdo_oe, force_hiz;

   int n_chk = 0;
   int n_fail = 0;

   int ms = S_TLR;
   int m_ir = 1;
   bit irq[$];
   bit drq[$];

   always #10 tck = ~tck;

   tap_top u0 (
      .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi),
      .pin_ring(pins), .tdo(tdo), .tdo_oe(tdo_oe), .force_hiz(force_hiz)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int nstate(input int s, input bit t);
      case (s)
         S_TLR:  return t ? S_TLR : S_RTI;
         S_RTI:  return t ? S_SDR : S_RTI;
         S_SDR:  return t ? S_SIR : S_CDR;
         S_CDR:  return t ? S_E1DR : S_SHDR;
         S_SHDR: return t ? S_E1DR : S_SHDR;
         S_E1DR: return t ? S_UDR : S_PDR;
         S_PDR:  return t ? S_E2DR : S_PDR;
         S_E2DR: return t ? S_UDR : S_SHDR;
         S_UDR:  return t ? S_SDR : S_RTI;
         S_SIR:  return t ? S_TLR : S_CIR;
         S_CIR:  return t ? S_E1IR : S_SHIR;
         S_SHIR: return t ? S_E1IR : S_SHIR;
         S_E1IR: return t ? S_UIR : S_PIR;
         S_PIR:  return t ? S_E2IR : S_PIR;
         S_E2IR: return t ? S_UIR : S_SHIR;
         default: return t ? S_SDR : S_RTI;
      endcase
   endfunction

   function automatic bit is_bnd(input int c);
      return (c == 0 || c == 2 || c == 4);
   endfunction

   task automatic model_edge(input bit t, input bit d);
      case (ms)
         S_CIR: begin irq = {}; irq.push_back(1); irq.push_back(0); irq.push_back(0); end
         S_SHIR: begin void'(irq.pop_front()); irq.push_back(d); end
         S_UIR: m_ir = irq[0] + 2 * irq[1] + 4 * irq[2];
         S_CDR: begin
            drq = {};
            if (is_bnd(m_ir)) for (int i = 0; i < BL; i++) drq.push_back(pins[i]);
            else if (m_ir == 1) for (int i = 0; i < 32; i++) drq.push_back(EXP_ID[i]);
            else drq.push_back(0);
         end
         S_SHDR: begin void'(drq.pop_front()); drq.push_back(d); end
         default: ;
      endcase
      ms = nstate(ms, t);
      if (ms == S_TLR) m_ir = 1;
   endtask

   task automatic model_cmp();
      bit eoe, ehz, etd;
      eoe = (ms == S_SHIR || ms == S_SHDR);
      ehz = (m_ir == 0 || m_ir == 2);
      check(tdo_oe == eoe, "R2 model tdo_oe", tdo_oe, eoe);
      check(force_hiz == ehz, "R6 model force_hiz", force_hiz, ehz);
      if (eoe) begin
         etd = (ms == S_SHIR) ? irq[0] : drq[0];
         check(tdo == etd, "R11 model tdo", tdo, etd);
      end
   endtask

   // one test clock: drive, rising edge, falling edge, sample
   task automatic cyc(input bit t, input bit d, output bit so);
      tms = t;
      tdi = d;
      @(posedge tck);
      model_edge(t, d);
      @(negedge tck);
      #5;
      so = tdo;
      model_cmp();
   endtask

   // from Run-Test/Idle back to Run-Test/Idle
   task automatic scan(input bit is_ir, input int n, input logic [127:0] din,
                       output logic [127:0] dout);
      bit b;
      dout = '0;
      cyc(1, 0, b);
      if (is_ir) cyc(1, 0, b);
      cyc(0, 0, b);
      cyc(0, 0, b);
      dout[0] = b;
      for (int i = 0; i < n; i++) begin
         cyc(i == n - 1, din[i], b);
         if (i < n - 1) dout[i+1] = b;
      end
      cyc(1, 0, b);
      cyc(0, 0, b);
   endtask

   task automatic set_ir(input logic [2:0] code);
      logic [127:0] o;
      scan(1, 3, {125'b0, code}, o);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [127:0] o;
      logic [127:0] din;
      bit b;

      repeat (3) @(negedge tck);
      #5;
      check(tdo_oe == 1'b0, "R2 reset tdo_oe", tdo_oe, 0);
      check(force_hiz == 1'b0, "R6 reset force_hiz", force_hiz, 0);
      rst_n = 1'b1;
      cyc(0, 0, b);

      // R3 R10: identification word straight after reset
      scan(0, 32, '0, o);
      check(o[31:0] == EXP_ID, "R3 R10 id word", o[31:0], EXP_ID);
      check(o[0] == 1'b1, "R10 id bit0", o[0], 1);
      check(o[27:18] == 10'b00111_00100, "R10 depth/width", o[27:18], 10'b00111_00100);

      // R4: capture pattern of the instruction register
      scan(1, 3, 128'h7, o);
      check(o[2:0] == 3'b001, "R4 ir capture", o[2:0], 3'b001);
      check(force_hiz == 1'b0, "R5 R6 bypass not floating", force_hiz, 0);

      // R9: bypass delay of one bit
      din = 128'hA5;
      scan(0, 8, din, o);
      check(o[0] == 1'b0, "R9 bypass capture", o[0], 0);
      check(o[7:1] == din[6:0], "R9 bypass delay", o[7:1], din[6:0]);

      // R5: reserved codes behave as bypass
      foreach (o[k]) if (k < 0) o[k] = 0;
      for (int c = 3; c <= 6; c++) begin
         if (c == 4) continue;
         set_ir(c[2:0]);
         din = 128'h3C;
         scan(0, 8, din, o);
         check(o[7:0] == {din[6:0], 1'b0}, "R5 reserved -> bypass", o[7:0], {din[6:0], 1'b0});
      end

      // R7 R11 R6: snapshot keeps outputs enabled
      set_ir(3'b100);
      check(force_hiz == 1'b0, "R6 snapshot no float", force_hiz, 0);
      pins = BL'({$urandom(), $urandom(), $urandom()});
      din = 128'hC3;
      scan(0, BL + 8, din, o);
      check(o[BL-1:0] == pins, "R7 ring capture", o[BL-1:0], pins);
      check(o[BL+7:BL] == din[7:0], "R11 chain length", o[BL+7:BL], din[7:0]);

      // R6 R5: floating ring sample
      set_ir(3'b010);
      check(force_hiz == 1'b1, "R6 code 010 floats", force_hiz, 1);
      set_ir(3'b000);
      check(force_hiz == 1'b1, "R6 code 000 floats", force_hiz, 1);
      pins = BL'({$urandom(), $urandom(), $urandom()});
      scan(0, BL, '0, o);
      check(o[BL-1:0] == pins, "R5 R7 code 000 boundary", o[BL-1:0], pins);

      // R8: pause and resume, then update has no effect
      cyc(1, 0, b); cyc(0, 0, b);
      cyc(0, 0, b);
      check(b == pins[0], "R8 first bit", b, pins[0]);
      cyc(0, 0, b);
      check(b == pins[1], "R8 second bit", b, pins[1]);
      cyc(1, 0, b);
      cyc(0, 0, b);
      check(tdo_oe == 1'b0, "R2 pause undriven", tdo_oe, 0);
      cyc(0, 0, b);
      cyc(1, 0, b);
      cyc(0, 0, b);
      check(b == pins[2], "R8 resume bit", b, pins[2]);
      cyc(1, 0, b);
      cyc(1, 0, b);
      check(force_hiz == 1'b1, "R8 update-dr inert", force_hiz, 1);
      cyc(0, 0, b);
      check(force_hiz == 1'b1, "R8 after update", force_hiz, 1);

      // R1: five high edges from inside a data shift
      cyc(1, 0, b); cyc(0, 0, b); cyc(0, 0, b);
      for (int i = 0; i < 5; i++) cyc(1, 0, b);
      check(force_hiz == 1'b0, "R1 R3 reset clears float", force_hiz, 0);
      check(tdo_oe == 1'b0, "R1 R2 reset undriven", tdo_oe, 0);
      cyc(0, 0, b);
      scan(0, 32, '0, o);
      check(o[31:0] == EXP_ID, "R1 R3 id after tms reset", o[31:0], EXP_ID);

      // R1: from Pause-IR
      cyc(1, 0, b); cyc(1, 0, b); cyc(0, 0, b); cyc(1, 0, b); cyc(0, 0, b);
      for (int i = 0; i < 5; i++) cyc(1, 0, b);
      check(tdo_oe == 1'b0, "R1 from pause-ir", tdo_oe, 0);

      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         if (i % 50 == 0) pins = BL'({$urandom(), $urandom(), $urandom()});
         cyc(($urandom() % 3) == 0, $urandom() % 2, b);
      end

      finish_run();
   end

endmodule